// File: doc/BRIEF.md
# Vector Burst Load/Store Mover

This block executes one unit-stride vector memory instruction at a time. The instruction names a byte base address, a destination or source vector register and an active element count. The block turns it into a run of single-word memory transactions in ascending element order. On a load it gathers the returned words into a 512-bit staging vector and then writes that vector to the register file in one masked write. On a store it reads the source register once, when the instruction is accepted, and hands out one 32-bit element per write request.

The memory side uses a request/grant handshake, plus a read-response strobe that follows each granted read. The register-file side has a combinational read port, which is used for store sources, and a write port with one enable bit per element, which is used for load results. A busy flag covers the whole operation. A one-cycle done pulse closes it.

Top module: `vec_burst_mover`

## Requirements
- R1: A command is taken on a clock edge where `cmd_valid_i` and `cmd_ready_o` are both high. `cmd_ready_o` is high only while the block is idle. `busy_o` is high from the cycle after acceptance up to and including the done cycle.
- R2: Element i uses byte address base + 4*i. Requests are issued in ascending i. A request that has not been granted keeps `mem_req_o`, `mem_addr_o` and `mem_we_o` steady until `mem_gnt_i`.
- R3: The element count is N = min(`cmd_len_i`, 16), and exactly N memory requests are issued. When N = 0 there is no memory request and no register write, and `done_o` rises in the cycle after acceptance.
- R4: A load issues its requests with `mem_we_o` = 0 and keeps at most one read outstanding. The next request appears only after the `mem_rvalid_i` of the previous read.
- R5: A load ends with exactly one register write, in the done cycle. In that write `rf_waddr_o` is the command's register and bits [32i+31:32i] of `rf_wdata_o` hold the word read for element i. Bit i of `rf_wmask_o` is set exactly for i < N, so elements at or above N keep their old contents.
- R6: A store reads its source through `rf_raddr_o` = `cmd_vreg_i` in the acceptance cycle. Element i carries bits [32i+31:32i] of that register on `mem_wdata_o`, with `mem_we_o` = 1. A store performs no register write.
- R7: `done_o` is a single-cycle pulse. It occurs in the cycle after the last element completes: for a store, the grant of the last write; for a load, the response of the last read.
- R8: While in reset and directly after it, the block is idle: `cmd_ready_o` = 1, and `busy_o`, `done_o`, `mem_req_o` and `rf_we_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Block idle, command can be taken |
| cmd_store_i | input | 1 | 1 = store, 0 = load |
| cmd_base_i | input | 32 | Byte base address |
| cmd_vreg_i | input | 5 | Vector register index |
| cmd_len_i | input | 7 | Requested element count (clamped to 16) |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Request byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| rf_raddr_o | output | 5 | Register-file read index |
| rf_rdata_i | input | 512 | Register-file read data |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 5 | Register-file write index |
| rf_wdata_o | output | 512 | Register-file write data |
| rf_wmask_o | output | 16 | Per-element write enable |

## Verification
The embedded properties assume that memory asserts `mem_gnt_i` only while a request is present. They also assume exactly one `mem_rvalid_i` per granted read, at the earliest one cycle after that grant, with read data valid in the same cycle. The bench memory model follows these rules. It grants only on the negative edge after it has seen a request, and it waits zero to two cycles before granting and before returning data. It never returns data while no read is pending. The register-file model returns read data combinationally for whatever index is presented, which is what the store capture relies on.

// File: rtl/vbm_pkg.sv
package vbm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/vbm_seq.sv
module vbm_seq
  import vbm_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int ELEM_W   = 32,
  parameter int NUM_ELEM = 16,
  parameter int LEN_W    = 7,
  localparam int IDX_W   = $clog2(NUM_ELEM),
  localparam int CNT_W   = $clog2(NUM_ELEM + 1),
  localparam int STEP    = ELEM_W / 8,
  localparam int SHIFT   = $clog2(STEP)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  logic                cmd_store_i,
  input  logic [ADDR_W-1:0]   cmd_base_i,
  input  logic [LEN_W-1:0]    cmd_len_i,
  output logic                cmd_ready_o,
  output logic                accept_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  input  logic                mem_gnt_i,
  input  logic                mem_rvalid_i,
  output logic [IDX_W-1:0]    idx_o,
  output logic                beat_o,
  output logic                commit_o,
  output logic [NUM_ELEM-1:0] mask_o
);
  seq_state_e          state_q;
  logic [IDX_W-1:0]    idx_q, last_q;
  logic [ADDR_W-1:0]   base_q;
  logic                store_q;
  logic [NUM_ELEM-1:0] mask_q, mask_c;
  logic [CNT_W-1:0]    cnt_c;
  logic                at_last;

  // clamp requested length and build the element enable mask
  always_comb begin
    cnt_c = (cmd_len_i > LEN_W'(NUM_ELEM)) ? CNT_W'(NUM_ELEM) : CNT_W'(cmd_len_i);
    for (int i = 0; i < NUM_ELEM; i++) mask_c[i] = (i < int'(cnt_c));
  end

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign accept_o    = cmd_ready_o && cmd_valid_i;
  assign busy_o      = !cmd_ready_o;
  assign done_o      = (state_q == ST_DONE);
  assign mem_req_o   = (state_q == ST_REQ);
  assign mem_we_o    = mem_req_o && store_q;
  assign mem_addr_o  = base_q + (ADDR_W'(idx_q) << SHIFT);
  assign idx_o       = idx_q;
  assign beat_o      = (state_q == ST_WAIT) && mem_rvalid_i;
  assign commit_o    = done_o && !store_q && mask_q[0];
  assign mask_o      = mask_q;
  assign at_last     = (idx_q == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      base_q  <= '0;
      store_q <= 1'b0;
      mask_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cmd_valid_i) begin
          store_q <= cmd_store_i;
          base_q  <= cmd_base_i;
          mask_q  <= mask_c;
          idx_q   <= '0;
          last_q  <= IDX_W'(cnt_c - CNT_W'(1));
          state_q <= (cnt_c == '0) ? ST_DONE : ST_REQ;
        end
        ST_REQ: if (mem_gnt_i) begin
          if (!store_q) state_q <= ST_WAIT;
          else if (at_last) state_q <= ST_DONE;
          else idx_q <= idx_q + IDX_W'(1);
        end
        ST_WAIT: if (mem_rvalid_i) begin
          if (at_last) state_q <= ST_DONE;
          else begin
            idx_q   <= idx_q + IDX_W'(1);
            state_q <= ST_REQ;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // address of the last accepted request, kept for the ordering check
  logic [ADDR_W-1:0] hs_addr_q;
  logic              hs_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_addr_q <= '0;
      hs_seen_q <= 1'b0;
    end else if (accept_o) begin
      hs_seen_q <= 1'b0;
    end else if (mem_req_o && mem_gnt_i) begin
      hs_seen_q <= 1'b1;
      hs_addr_q <= mem_addr_o;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))); // R2
  AST_ADDR_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && hs_seen_q) |-> (mem_addr_o == hs_addr_q + ADDR_W'(STEP))); // R2
  AST_LOAD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_gnt_i && !mem_we_o) |=> !mem_req_o); // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !commit_o)); // R1
endmodule

// File: rtl/vbm_lanes.sv
module vbm_lanes #(
  parameter int ELEM_W   = 32,
  parameter int NUM_ELEM = 16,
  localparam int IDX_W   = $clog2(NUM_ELEM),
  localparam int VLEN    = ELEM_W * NUM_ELEM
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cap_i,
  input  logic [VLEN-1:0]     src_i,
  input  logic                beat_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [ELEM_W-1:0]   rdata_i,
  input  logic                commit_i,
  input  logic [NUM_ELEM-1:0] mask_i,
  output logic [ELEM_W-1:0]   elem_o,
  output logic [VLEN-1:0]     vec_o
);
  for (genvar g = 0; g < NUM_ELEM; g++) begin : g_lane
    logic [ELEM_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (cap_i) q <= src_i[g*ELEM_W +: ELEM_W];
      else if (beat_i && idx_i == IDX_W'(g)) q <= rdata_i;
    end
    assign vec_o[g*ELEM_W +: ELEM_W] = q;
  end

  assign elem_o = vec_o[idx_i*ELEM_W +: ELEM_W];

  AST_WMASK_PREFIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> (mask_i != '0 && ((mask_i + NUM_ELEM'(1)) & mask_i) == '0)); // R5
endmodule

// File: rtl/vec_burst_mover.sv
module vec_burst_mover #(
  parameter int ADDR_W   = 32,
  parameter int ELEM_W   = 32,
  parameter int NUM_ELEM = 16,
  parameter int NUM_REGS = 32,
  parameter int LEN_W    = 7,
  localparam int VLEN    = ELEM_W * NUM_ELEM,
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int IDX_W   = $clog2(NUM_ELEM)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  output logic                cmd_ready_o,
  input  logic                cmd_store_i,
  input  logic [ADDR_W-1:0]   cmd_base_i,
  input  logic [REG_W-1:0]    cmd_vreg_i,
  input  logic [LEN_W-1:0]    cmd_len_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [ELEM_W-1:0]   mem_wdata_o,
  input  logic                mem_gnt_i,
  input  logic                mem_rvalid_i,
  input  logic [ELEM_W-1:0]   mem_rdata_i,
  output logic [REG_W-1:0]    rf_raddr_o,
  input  logic [VLEN-1:0]     rf_rdata_i,
  output logic                rf_we_o,
  output logic [REG_W-1:0]    rf_waddr_o,
  output logic [VLEN-1:0]     rf_wdata_o,
  output logic [NUM_ELEM-1:0] rf_wmask_o
);
  logic             accept, beat, commit;
  logic [IDX_W-1:0] idx;
  logic [REG_W-1:0] vreg_q;

  vbm_seq #(
    .ADDR_W(ADDR_W), .ELEM_W(ELEM_W), .NUM_ELEM(NUM_ELEM), .LEN_W(LEN_W)
  ) u_seq (
    .clk_i, .rst_ni,
    .cmd_valid_i, .cmd_store_i, .cmd_base_i, .cmd_len_i,
    .cmd_ready_o,
    .accept_o   (accept),
    .busy_o, .done_o,
    .mem_req_o, .mem_we_o, .mem_addr_o,
    .mem_gnt_i, .mem_rvalid_i,
    .idx_o      (idx),
    .beat_o     (beat),
    .commit_o   (commit),
    .mask_o     (rf_wmask_o)
  );

  vbm_lanes #(.ELEM_W(ELEM_W), .NUM_ELEM(NUM_ELEM)) u_lanes (
    .clk_i, .rst_ni,
    .cap_i    (accept && cmd_store_i),
    .src_i    (rf_rdata_i),
    .beat_i   (beat),
    .idx_i    (idx),
    .rdata_i  (mem_rdata_i),
    .commit_i (commit),
    .mask_i   (rf_wmask_o),
    .elem_o   (mem_wdata_o),
    .vec_o    (rf_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vreg_q <= '0;
    else if (accept) vreg_q <= cmd_vreg_i;
  end

  assign rf_raddr_o = cmd_vreg_i;
  assign rf_waddr_o = vreg_q;
  assign rf_we_o    = commit;

  AST_WRITE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> $stable(rf_waddr_o)); // R5
endmodule

// File: tb/vec_burst_mover_test.sv
`timescale 1ns/1ps
module vec_burst_mover_test;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cmd_valid_i = 1'b0;
  logic         cmd_store_i = 1'b0;
  logic [31:0]  cmd_base_i = '0;
  logic [4:0]   cmd_vreg_i = '0;
  logic [6:0]   cmd_len_i = '0;
  logic         cmd_ready_o, busy_o, done_o;
  logic         mem_req_o, mem_we_o;
  logic [31:0]  mem_addr_o, mem_wdata_o;
  logic         mem_gnt_i = 1'b0;
  logic         mem_rvalid_i = 1'b0;
  logic [31:0]  mem_rdata_i = '0;
  logic [4:0]   rf_raddr_o, rf_waddr_o;
  logic [511:0] rf_rdata_i, rf_wdata_o;
  logic         rf_we_o;
  logic [15:0]  rf_wmask_o;

  always #2.5 clk = ~clk;

  vec_burst_mover uut (
    .clk_i(clk), .rst_ni,
    .cmd_valid_i, .cmd_ready_o, .cmd_store_i, .cmd_base_i, .cmd_vreg_i, .cmd_len_i,
    .busy_o, .done_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_gnt_i, .mem_rvalid_i, .mem_rdata_i,
    .rf_raddr_o, .rf_rdata_i, .rf_we_o, .rf_waddr_o, .rf_wdata_o, .rf_wmask_o
  );

  int errors = 0;
  int checks = 0;

  task automatic check(bit ok, string tag, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9bdf;
  endfunction

  // register file model
  logic [511:0] rf [32];
  assign rf_rdata_i = rf[rf_raddr_o];
  always @(posedge clk) begin
    if (!rst_ni) begin
      for (int r = 0; r < 32; r++)
        for (int e = 0; e < 16; e++)
          rf[r][32*e +: 32] <= {r[7:0], e[7:0], 16'ha5c3};
    end else if (rf_we_o) begin
      for (int e = 0; e < 16; e++)
        if (rf_wmask_o[e]) rf[rf_waddr_o][32*e +: 32] <= rf_wdata_o[32*e +: 32];
    end
  end

  // expected transaction stream
  logic [31:0] exp_addr_q [$];
  bit          exp_we_q   [$];
  logic [31:0] exp_data_q [$];

  // memory responder and per-cycle comparison against the expected stream
  bit          pend = 0;
  bit          exp_done = 0;
  logic [31:0] pend_addr = '0;
  int          gnt_wait = 0;
  int          rd_wait = 0;

  always @(negedge clk) begin
    if (!rst_ni) begin
      mem_gnt_i = 0; mem_rvalid_i = 0; pend = 0; exp_done = 0;
    end else begin
      if (exp_done) begin
        check(done_o === 1'b1, "R7 done one cycle after last element", done_o, 1);
        exp_done = 0;
      end
      if (!busy_o && mem_req_o) check(0, "R1 request while idle", mem_req_o, 0);
      mem_gnt_i = 0;
      mem_rvalid_i = 0;
      if (pend) begin
        if (mem_req_o) check(0, "R4 request with read outstanding", mem_req_o, 0);
        if (rd_wait == 0) begin
          mem_rvalid_i = 1;
          mem_rdata_i = mem_word(pend_addr);
          pend = 0;
          if (exp_addr_q.size() == 0) exp_done = 1;
        end else rd_wait--;
      end else if (mem_req_o) begin
        if (gnt_wait == 0) begin
          mem_gnt_i = 1;
          gnt_wait = $urandom_range(0, 2);
          if (exp_addr_q.size() == 0) begin
            check(0, "R3 extra memory request", mem_addr_o, 0);
          end else begin
            logic [31:0] ea, ed;
            bit ew;
            ea = exp_addr_q.pop_front();
            ew = exp_we_q.pop_front();
            ed = exp_data_q.pop_front();
            check(mem_addr_o === ea, "R2 element address", mem_addr_o, ea);
            check(mem_we_o === ew, ew ? "R6 write flag" : "R4 read flag", mem_we_o, ew);
            if (ew) check(mem_wdata_o === ed, "R6 store element data", mem_wdata_o, ed);
            if (mem_we_o) begin
              if (exp_addr_q.size() == 0) exp_done = 1;
            end else begin
              pend = 1;
              pend_addr = mem_addr_o;
              rd_wait = $urandom_range(0, 2);
            end
          end
        end else gnt_wait--;
      end
    end
  end

  task automatic run_cmd(bit st, logic [31:0] base, int vreg, int len);
    int n;
    int cyc;
    logic [511:0] snap, expv;
    n = (len > 16) ? 16 : len;
    snap = rf[vreg];
    expv = snap;
    for (int i = 0; i < n; i++) begin
      exp_addr_q.push_back(base + 32'(4 * i));
      exp_we_q.push_back(st);
      exp_data_q.push_back(snap[32*i +: 32]);
      if (!st) expv[32*i +: 32] = mem_word(base + 32'(4 * i));
    end
    check(cmd_ready_o === 1'b1, "R1 ready while idle", cmd_ready_o, 1);
    cmd_valid_i = 1; cmd_store_i = st; cmd_base_i = base;
    cmd_vreg_i = 5'(vreg); cmd_len_i = 7'(len);
    @(negedge clk);
    cmd_valid_i = 0;
    cmd_vreg_i = 5'(vreg + 1);
    cyc = 0;
    while (!done_o && cyc < 400) begin
      check(busy_o === 1'b1, "R1 busy during operation", busy_o, 1);
      @(negedge clk);
      cyc++;
    end
    check(busy_o === 1'b1, "R1 busy in done cycle", busy_o, 1);
    check(done_o === 1'b1, "R7 done reached", done_o, 1);
    if (n == 0) check(cyc == 0, "R3 empty command finishes next cycle", cyc, 0);
    check(rf_we_o === (!st && n > 0), "R5 register write only for nonempty load", rf_we_o, !st && n > 0);
    if (!st && n > 0) begin
      check(rf_waddr_o === 5'(vreg), "R5 write register index", rf_waddr_o, vreg);
      check(rf_wmask_o === 16'((32'd1 << n) - 1), "R5 element write mask", rf_wmask_o, (32'd1 << n) - 1);
    end
    check(exp_addr_q.size() == 0, "R3 request count", exp_addr_q.size(), 0);
    @(negedge clk);
    check(done_o === 1'b0 && busy_o === 1'b0, "R7 single done pulse", {done_o, busy_o}, 0);
    check(rf[vreg] === expv, st ? "R6 store leaves register" : "R5 register contents after load", rf[vreg], expv);
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(negedge clk);
    check(cmd_ready_o === 1'b1 && busy_o === 1'b0 && done_o === 1'b0 &&
          mem_req_o === 1'b0 && rf_we_o === 1'b0, "R8 reset state",
          {cmd_ready_o, busy_o, done_o, mem_req_o, rf_we_o}, 5'b10000);
    rst_ni = 1;
    @(negedge clk);
    check(cmd_ready_o === 1'b1 && busy_o === 1'b0 && mem_req_o === 1'b0, "R8 idle after reset",
          {cmd_ready_o, busy_o, mem_req_o}, 3'b100);
    run_cmd(0, 32'h0000_1000, 3, 16);   // R5 full load
    run_cmd(0, 32'h0000_2040, 7, 5);    // R5 partial, upper elements kept
    run_cmd(0, 32'h0000_3000, 0, 40);   // R3 clamp
    run_cmd(1, 32'h0000_4000, 3, 16);   // R6 full store
    run_cmd(1, 32'h0000_5004, 31, 1);   // R6 single element
    run_cmd(0, 32'h0000_6000, 9, 0);    // R3 empty load
    run_cmd(1, 32'h0000_7000, 9, 0);    // R3 empty store
    run_cmd(1, 32'h8000_0010, 7, 9);    // R2 high addresses
    run_cmd(0, 32'h0000_9000, 31, 16);  // R4 back to back
    run_cmd(1, 32'h0000_a000, 31, 127); // R3 clamp on store
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule